// File: doc/BRIEF.md
# Exponential Handshake Delay Timer

This block is a delay timer that software starts and then polls. It exposes one 32-bit control word. Software writes that word with a start flag and a 3-bit exponent n. The timer then waits for 50 × 2^n base ticks and raises a completion flag that stays readable. Base ticks come from a strobe input, so the time unit can be any clock divider that the surrounding logic chooses. An optional one-cycle completion pulse is also available for logic that does not want to poll.

The start flag reads back as 1 for exactly one cycle, while the counter loads, and then clears by itself. A new start at any time abandons a count that is in flight. It clears the completion flag and reloads the counter from the new exponent. Writes that do not carry the start flag leave the block untouched.

Top module: `exp_delay_timer`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows a read word of zero and a low completion pulse.
- R2: A write with bit 16 set is a start. In the next cycle the read word shows bit 16 = 1, bit 20 = 0 and bits 19:17 equal to the written exponent. One cycle later bit 16 reads 0.
- R3: After the cycle in which bit 16 reads 1, bit 20 becomes 1 in the cycle after the edge that samples the (50 << n)-th asserted tick strobe, and not earlier.
- R4: Edges where the tick strobe is low do not advance the count. A tick at the edge that ends the start-flag cycle is not counted either.
- R5: Once set, bit 20 stays 1 until the next start or reset. Writes without bit 16 do not change any bit of the read word, whatever they carry in bits 20 and 19:17.
- R6: A start while a count is running discards that count. The full 50 << n of the new exponent is then counted, and the new exponent is shown in bits 19:17.
- R7: The completion pulse is high for exactly the one cycle in which bit 20 first reads 1 after a count.
- R8: If a start arrives at the same edge as the final counted tick, the start wins: bit 20 stays 0 and a fresh count begins.
- R9: All read bits other than 20, 19:17 and 16 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base tick strobe; each high edge is one tick of the delay |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Written control word (bit 16 start, bits 19:17 exponent) |
| rd_data_o | output | 32 | Read-back control word (bit 16 start pending, 19:17 exponent, 20 done) |
| done_pulse_o | output | 1 | One-cycle pulse when a count completes |

## Verification
The assertions check on every cycle that the start flag clears itself and that a start clears done. They also check that done holds until the next start and that ignored writes leave the exponent alone. The pulse is checked to be single and aligned with the rising done flag. A tick counter in the checker confirms that done rises only after exactly 50 << n counted ticks. Only the bench scenarios can show the timing under gapped or stopped tick strobes, a restart in the middle of a count, a start on the final tick, and the longest exponent. In those scenarios a behavioural model is compared against the read word on every clock.

// File: rtl/dly_timer_pkg.sv
// Package: register layout and shared types of the exponential delay timer.
// Assumes a 32-bit control word; field positions are fixed because software
// decodes them.
package dly_timer_pkg;
    localparam int REG_W    = 32;
    localparam int GO_BIT   = 16;
    localparam int EXP_LSB  = 17;
    localparam int EXP_W    = 3;
    localparam int DONE_BIT = 20;
    localparam int EXP_MSB  = EXP_LSB + EXP_W - 1;

    localparam logic [REG_W-1:0] FIELD_MASK =
        (REG_W'(1) << GO_BIT) | (REG_W'(1) << DONE_BIT) |
        (((REG_W'(1) << EXP_W) - REG_W'(1)) << EXP_LSB);

    typedef logic [EXP_W-1:0] exp_t;

    typedef struct packed {
        logic go;
        exp_t exp;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } cnt_state_t;
endpackage

// File: rtl/dly_cmd_decode.sv
// Module: dly_cmd_decode
// Splits a written control word into a start request and an exponent.
// Assumes the write strobe is one cycle per write; bits outside the start
// and exponent fields carry no command and are discarded here.
module dly_cmd_decode
    import dly_timer_pkg::*;
(
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output cmd_t             cmd_o,
    output logic             start_o
);
    logic unused_bits;

    // Pick the command fields out of the written word.
    always_comb begin
        cmd_o.go  = wr_data_i[GO_BIT];
        cmd_o.exp = wr_data_i[EXP_MSB:EXP_LSB];
    end

    // A start is a write that carries the start flag.
    assign start_o = wr_en_i & cmd_o.go;

    // Bits with no command meaning are intentionally dropped.
    assign unused_bits = ^(wr_data_i & ~(FIELD_MASK & ~(REG_W'(1) << DONE_BIT)));
endmodule

// File: rtl/dly_countdown.sv
// Module: dly_countdown
// Down-counter that spans 50 << n base ticks. A start moves it to an armed
// cycle in which it loads, and then it counts qualified ticks down to one.
// Assumes exp_i is already the latched exponent when the armed cycle runs.
module dly_countdown
    import dly_timer_pkg::*;
#(
    parameter int BASE_TICKS = 50,
    parameter int CNT_W      = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  exp_t exp_i,
    input  logic tick_i,
    output logic armed_o,
    output logic finish_o
);
    cnt_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             last_tick;

    // Load value: the base span scaled by a power of two.
    assign load_val = CNT_W'(BASE_TICKS) << exp_i;

    // The tick that brings the count from one to zero.
    assign last_tick = (state_q == ST_COUNT) && tick_i && (cnt_q == CNT_W'(1));

    // A start at the same edge suppresses completion.
    assign finish_o = last_tick && !start_i;
    assign armed_o  = (state_q == ST_ARMED);

    // State and count update; a start has priority over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (start_i) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_ARMED: begin
                    cnt_q   <= load_val;
                    state_q <= ST_COUNT;
                end
                ST_COUNT: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_W'(1)) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/dly_status_reg.sv
// Module: dly_status_reg
// Holds the latched exponent and the done flag, produces the read word and
// the optional completion pulse. Assumes finish_i never coincides with
// start_i (the counter already gives the start priority).
module dly_status_reg
    import dly_timer_pkg::*;
#(
    parameter bit PULSE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  exp_t             cmd_exp_i,
    input  logic             armed_i,
    input  logic             finish_i,
    output exp_t             exp_o,
    output logic [REG_W-1:0] rd_data_o,
    output logic             done_pulse_o
);
    exp_t exp_q;
    logic done_q;

    // Latch the exponent only when a start is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (start_i) begin
            exp_q <= cmd_exp_i;
        end
    end

    // Done flag: cleared by a start, set by completion, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (start_i) begin
            done_q <= 1'b0;
        end else if (finish_i) begin
            done_q <= 1'b1;
        end
    end

    // Optional completion pulse, registered alongside the done flag.
    generate
        if (PULSE_EN) begin : g_pulse
            logic pulse_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pulse_q <= 1'b0;
                end else begin
                    pulse_q <= finish_i;
                end
            end
            assign done_pulse_o = pulse_q;
        end else begin : g_no_pulse
            assign done_pulse_o = 1'b0;
        end
    endgenerate

    // Assemble the read word from the held fields.
    always_comb begin
        rd_data_o                   = '0;
        rd_data_o[GO_BIT]           = armed_i;
        rd_data_o[EXP_MSB:EXP_LSB]  = exp_q;
        rd_data_o[DONE_BIT]         = done_q;
    end

    assign exp_o = exp_q;
endmodule

// File: rtl/exp_delay_timer.sv
// Module: exp_delay_timer (top)
// Software-started delay of 50 << n base ticks with a polled done flag.
// Assumes a single clock, a synchronous active-low reset and a tick strobe
// that is already synchronous to clk.
module exp_delay_timer
    import dly_timer_pkg::*;
#(
    parameter int BASE_TICKS = 50,
    parameter bit PULSE_EN   = 1'b1,
    localparam int MAX_SPAN  = BASE_TICKS << ((1 << EXP_W) - 1),
    localparam int CNT_W     = $clog2(MAX_SPAN + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    output logic        done_pulse_o
);
    cmd_t cmd;
    logic start;
    logic armed;
    logic finish;
    exp_t exp_held;

    dly_cmd_decode u_dec (
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .cmd_o    (cmd),
        .start_o  (start)
    );

    dly_countdown #(
        .BASE_TICKS(BASE_TICKS),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .exp_i   (exp_held),
        .tick_i  (tick_i),
        .armed_o (armed),
        .finish_o(finish)
    );

    dly_status_reg #(
        .PULSE_EN(PULSE_EN)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cmd_exp_i   (cmd.exp),
        .armed_i     (armed),
        .finish_i    (finish),
        .exp_o       (exp_held),
        .rd_data_o   (rd_data_o),
        .done_pulse_o(done_pulse_o)
    );
endmodule

// File: rtl/exp_delay_timer_chk.sv
// Module: exp_delay_timer_chk
// Port-level checker for exp_delay_timer, attached by bind. Tracks counted
// ticks itself so the delay length is checked without deep $past windows.
module exp_delay_timer_chk
    import dly_timer_pkg::*;
#(
    parameter int BASE_TICKS = 50,
    parameter bit PULSE_EN   = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        wr_en_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] rd_data_o,
    input logic        done_pulse_o
);
    logic        wr_start;
    logic        rd_go;
    logic        rd_done;
    exp_t        rd_exp;
    int unsigned ticks_q;

    assign wr_start = wr_en_i && wr_data_i[GO_BIT];
    assign rd_go    = rd_data_o[GO_BIT];
    assign rd_done  = rd_data_o[DONE_BIT];
    assign rd_exp   = rd_data_o[EXP_MSB:EXP_LSB];

    // Count ticks that the timer should accept since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_start) begin
            ticks_q <= 0;
        end else if (!rd_go && !rd_done && tick_i) begin
            ticks_q <= ticks_q + 1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o == 32'd0 && !done_pulse_o)); // R1

    AST_START_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (rd_go && !rd_done && rd_exp == $past(wr_data_i[EXP_MSB:EXP_LSB]))); // R2

    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !wr_start) |=> !rd_go); // R2

    AST_SPAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> (ticks_q == (BASE_TICKS << rd_exp))); // R3

    AST_NO_DONE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> $past(tick_i)); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !wr_start) |=> rd_done); // R5

    AST_EXP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_start |=> $stable(rd_exp)); // R5

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~FIELD_MASK) == 32'd0); // R9

    generate
        if (PULSE_EN) begin : g_pulse_chk
            AST_PULSE_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rd_done) |-> done_pulse_o); // R7

            AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                done_pulse_o |=> !done_pulse_o); // R7

            AST_PULSE_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
                done_pulse_o |-> rd_done); // R7
        end
    endgenerate
endmodule

bind exp_delay_timer exp_delay_timer_chk #(
    .BASE_TICKS(BASE_TICKS),
    .PULSE_EN  (PULSE_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .done_pulse_o(done_pulse_o)
);

// File: tb/exp_delay_timer_test.sv
// Bench for exp_delay_timer: scenario checks plus a behavioural model
// compared against the read word and pulse on every clock.
module exp_delay_timer_test;
    localparam int BASE = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = 32'd0;
    logic [31:0] rd_data_o;
    logic        done_pulse_o;

    int checks = 0;
    int fails = 0;
    int tick_mode = 0;   // 0 always, 1 every other cycle, 2 never
    bit tick_phase = 1'b0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    // Behavioural model state
    bit m_go, m_done, m_run, m_pulse;
    int m_exp, m_left;

    exp_delay_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .done_pulse_o(done_pulse_o)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        return (32'(m_done) << 20) | (32'(m_exp) << 17) | (32'(m_go) << 16);
    endfunction

    // Reference model: advances on each clock from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_go = 0; m_done = 0; m_run = 0; m_pulse = 0; m_exp = 0; m_left = 0;
        end else begin
            m_pulse = 0;
            if (wr_en_i && wr_data_i[16]) begin
                m_go = 1; m_exp = int'(wr_data_i[19:17]); m_done = 0; m_run = 0;
            end else if (m_go) begin
                m_go = 0; m_run = 1; m_left = BASE * (1 << m_exp);
            end else if (m_run && tick_i) begin
                m_left--;
                if (m_left == 0) begin
                    m_run = 0; m_done = 1; m_pulse = 1;
                end
            end
        end
    end

    // Tick strobe pattern and per-cycle model comparison, away from the edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R3 model word", rd_data_o, model_word());
            check("R7 model pulse", 32'(done_pulse_o), 32'(m_pulse));
        end
        tick_phase = ~tick_phase;
        tick_i = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? tick_phase : 1'b0;
    end

    task automatic write_word(logic [31:0] w);
        wr_en_i = 1'b1;
        wr_data_i = w;
        @(negedge clk);
        wr_en_i = 1'b0;
        wr_data_i = 32'd0;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] start_word(int n);
        return 32'h0001_0000 | (32'(n) << 17);
    endfunction

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", rd_data_o, 32'd0);
        check("R1 reset pulse", 32'(done_pulse_o), 32'd0);
        model_on = 1'b1;

        // n = 0, tick every cycle
        tick_mode = 0;
        write_word(start_word(0));
        check("R2 start visible", rd_data_o, 32'h0001_0000);
        step(1);
        check("R2 start self-clears", rd_data_o, 32'h0000_0000);
        step(BASE - 1);
        check("R3 not yet done n=0", rd_data_o[20], 1'b0);
        step(1);
        check("R3 done n=0", rd_data_o, 32'h0010_0000);
        check("R7 pulse high", 32'(done_pulse_o), 32'd1);
        step(1);
        check("R7 pulse single", 32'(done_pulse_o), 32'd0);
        check("R5 done held", rd_data_o[20], 1'b1);

        // Write without start, carrying done and exponent bits
        write_word(32'hFFFE_FFFF);
        step(2);
        check("R5 ignored write", rd_data_o, 32'h0010_0000);
        check("R9 unused bits", rd_data_o & ~32'h001F_0000, 32'd0);

        // n = 2 with gapped ticks: 200 ticks over about 400 cycles
        tick_mode = 1;
        write_word(start_word(2));
        check("R2 exponent shown", rd_data_o, 32'h0005_0000);
        step(300);
        check("R4 gapped not done", rd_data_o[20], 1'b0);
        step(110);
        check("R4 gapped done", rd_data_o, 32'h0014_0000);

        // Stopped ticks freeze the count
        tick_mode = 2;
        write_word(start_word(1));
        step(400);
        check("R4 stopped ticks", rd_data_o, 32'h0002_0000);
        tick_mode = 0;
        step(99);
        check("R4 resumes not done", rd_data_o[20], 1'b0);
        step(2);
        check("R4 resumes done", rd_data_o, 32'h0012_0000);

        // Restart mid-count with a smaller exponent
        write_word(start_word(3));
        step(101);
        write_word(start_word(0));
        check("R6 restart visible", rd_data_o, 32'h0001_0000);
        step(BASE);
        check("R6 new span not done", rd_data_o, 32'h0000_0000);
        step(1);
        check("R6 new span done", rd_data_o, 32'h0010_0000);

        // Start on the final tick
        write_word(start_word(0));
        step(BASE);
        write_word(start_word(1));
        check("R8 start wins", rd_data_o, 32'h0003_0000);
        check("R8 no pulse", 32'(done_pulse_o), 32'd0);
        step(100);
        check("R8 fresh not done", rd_data_o[20], 1'b0);
        step(1);
        check("R8 fresh done", rd_data_o, 32'h0012_0000);

        // Longest exponent
        write_word(start_word(7));
        step(1 + BASE * 128 - 1);
        check("R3 n=7 not done", rd_data_o[20], 1'b0);
        step(1);
        check("R3 n=7 done", rd_data_o, 32'h001E_0000);

        // Reset mid-count
        write_word(start_word(4));
        step(20);
        model_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-count", rd_data_o, 32'd0);
        rst_n = 1'b1;
        step(2);
        check("R1 stays idle", rd_data_o, 32'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule